// File: doc/BRIEF.md
# Processor Bus Region Decoder

This block sits between one processor's load/store unit and the memories around it. Each cycle it may accept one request: a byte, halfword or word load or store, or an instruction fetch. It picks a target from the top byte of the address. It masks the address down to an offset inside that target and drives a single backing-memory port or a pair of IO register ports. On the following cycle it returns a registered response with the load data, the wait-cycle cost and an error flag.

Several address windows have special rules. The working-RAM window is split between a shared RAM and a private RAM. The share size is programmable, and a share size of zero sends every access to the private RAM. The tightly coupled memory window and its mirror accept an access only below a limit, which is 512 shifted left by a control field. Main RAM repeats throughout its window. Unaligned loads come back rotated. IO word reads are built from two halfword reads. A fetch from an invalid place returns a fixed trap word that is undefined in both instruction encodings, so a core that runs away stops at once.

Top module: `bus_region_decoder`

## Requirements
- R1: After reset rspValid, rspErr and rspWait are 0 and no memory or IO strobe is active. The shared working-RAM size starts at parameter SHARED_RESET (default 0x8000).
- R2: The target is chosen by reqAddr[31:24]: 0x00 and 0x01 tightly coupled memory, 0x02 main RAM, 0x03 working RAM, 0x04 IO, 0xFF boot ROM, anything else unmapped. memSel encodes private RAM 0, shared RAM 1, main RAM 2, tightly coupled memory 3, boot ROM 4. Only one of the memory port and the IO port is strobed, and only while reqValid is high.
- R3: A store drives memOffset word-aligned. A byte store replicates data[7:0] into all four lanes with memBe = 1 << addr[1:0]. A halfword store replicates data[15:0] with memBe 4'b1100 when addr[1] is 1, else 4'b0011. A word store drives memBe 4'b1111.
- R4: Main RAM offsets are the address masked with (MAIN_SIZE - 1), so the window repeats every MAIN_SIZE bytes.
- R5: In working RAM, an address at or above PRIV_BASE, or any address while the shared size is 0, goes to the private RAM masked with (PRIV_SIZE - 1). Otherwise it goes to the shared RAM masked with (shared size - 1).
- R6: A cycle with cfgWe high loads cfgShared into the shared size. The new size takes effect from the next request.
- R7: A word load returns the aligned word rotated right by 8*addr[1:0]. A halfword load returns the selected halfword, zero-extended and rotated right by 8*addr[0]. A byte load returns the selected byte, zero-extended.
- R8: rspWait is 2 for a load or fetch and 1 for a store, in the response cycle.
- R9: IO addresses keep reqAddr[23:0]. A word IO read sets ioAddrLo to the address with bits [1:0] cleared, and ioAddrHi to ioAddrLo with bit 1 set; the result is {ioRdHi, ioRdLo} before rotation. Halfword and byte IO reads use the address with bit 0 cleared on ioAddrLo.
- R10: The tightly coupled window and its mirror accept an access only when the full address is below 512 << tcmSizeField. The offset is then the address masked with (TCM_SIZE - 1).
- R11: A fetch that faults returns 32'hE710B710. Faults include an unmapped region, a rejected tightly coupled access, and an absent boot ROM.
- R12: A faulting request raises rspErr for its response cycle only. A faulting store strobes neither port. A faulting load that is not a fetch returns 0. Stores to the boot ROM always fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Byte address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqWrite | input | 1 | 1 for store |
| reqFetch | input | 1 | Load is an instruction fetch |
| reqWdata | input | 32 | Store data, right-aligned |
| tcmSizeField | input | 5 | Tightly coupled window size shift |
| cfgWe | input | 1 | Load shared working-RAM size |
| cfgShared | input | 24 | New shared working-RAM size |
| memEn | output | 1 | Backing memory access strobe |
| memSel | output | 3 | Backing memory target code |
| memWe | output | 1 | Backing memory write |
| memOffset | output | 24 | Word-aligned masked offset |
| memBe | output | 4 | Byte lane enables |
| memWdata | output | 32 | Lane-replicated store data |
| memRdata | input | 32 | Word read at memOffset, same cycle |
| ioRe | output | 1 | IO read strobe |
| ioWe | output | 1 | IO write strobe |
| ioAddrLo | output | 24 | IO address, low half / write address |
| ioAddrHi | output | 24 | IO address of upper half of a word read |
| ioRdLo | input | 16 | IO data read at ioAddrLo |
| ioRdHi | input | 16 | IO data read at ioAddrHi |
| ioWdata | output | 32 | Lane-replicated IO store data |
| ioBe | output | 4 | IO byte lane enables |
| rspValid | output | 1 | Response present |
| rspData | output | 32 | Load result (0 for stores) |
| rspWait | output | 2 | Access wait cycles |
| rspErr | output | 1 | Fault pulse |

## Verification
The assertions assume that memRdata, ioRdLo and ioRdHi settle in the same cycle as the strobes. They also assume that the request inputs are defined whenever reqValid is high. Checks that look back one cycle rely on the bench holding every request for exactly one cycle, with reqValid low between requests, so each response lines up with a single past request. The stimulus drives all inputs on the falling edge from known zero values. The bench's memory model reads combinationally from the strobed offset, which keeps these assumptions true.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

  typedef enum logic [2:0] {
    TGT_PRIV   = 3'd0,
    TGT_SHARED = 3'd1,
    TGT_MAIN   = 3'd2,
    TGT_TCM    = 3'd3,
    TGT_ROM    = 3'd4,
    TGT_IO     = 3'd5,
    TGT_NONE   = 3'd7
  } target_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [7:0] REG_TCM        = 8'h00;
  localparam logic [7:0] REG_TCM_MIRROR = 8'h01;
  localparam logic [7:0] REG_MAIN       = 8'h02;
  localparam logic [7:0] REG_WORK       = 8'h03;
  localparam logic [7:0] REG_IO         = 8'h04;
  localparam logic [7:0] REG_ROM        = 8'hFF;

  localparam logic [31:0] TRAP_WORD = 32'hE710B710;

  // strobes from control to datapath
  typedef struct packed {
    logic    memRead;
    logic    memWrite;
    logic    ioRead;
    logic    ioWrite;
    logic    fault;
    logic    fetchTrap;
    target_e target;
  } ctlStrobe_t;

endpackage

// File: rtl/busdec_ctrl.sv
module busdec_ctrl
  import busdec_pkg::*;
#(
  parameter int          OFS_W        = 24,
  parameter logic [31:0] PRIV_BASE    = 32'h0380_0000,
  parameter bit          ROM_PRESENT  = 1'b0,
  parameter logic [OFS_W-1:0] SHARED_RESET = 24'h00_8000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [31:0]      reqAddr,
  input  logic             reqWrite,
  input  logic             reqFetch,
  input  logic [4:0]       tcmSizeField,
  input  logic             cfgWe,
  input  logic [OFS_W-1:0] cfgShared,
  output ctlStrobe_t       strb,
  output logic [OFS_W-1:0] sharedSize
);

  logic [7:0]  region;
  logic [63:0] tcmLimit;
  logic        tcmOk;
  logic        isMem;
  target_e     target;

  always_ff @(posedge clk) begin
    if (!rstN)      sharedSize <= SHARED_RESET;
    else if (cfgWe) sharedSize <= cfgShared;
  end

  assign region   = reqAddr[31:24];
  assign tcmLimit = 64'd512 << tcmSizeField;
  assign tcmOk    = {32'd0, reqAddr} < tcmLimit;

  always_comb begin
    unique case (region)
      REG_TCM, REG_TCM_MIRROR: target = tcmOk ? TGT_TCM : TGT_NONE;
      REG_MAIN:                target = TGT_MAIN;
      REG_WORK:                target = (reqAddr >= PRIV_BASE || sharedSize == '0)
                                        ? TGT_PRIV : TGT_SHARED;
      REG_IO:                  target = TGT_IO;
      REG_ROM:                 target = (ROM_PRESENT && !reqWrite) ? TGT_ROM : TGT_NONE;
      default:                 target = TGT_NONE;
    endcase
  end

  assign isMem = (target != TGT_IO) && (target != TGT_NONE);

  always_comb begin
    strb.target    = target;
    strb.memRead   = reqValid && !reqWrite && isMem;
    strb.memWrite  = reqValid &&  reqWrite && isMem;
    strb.ioRead    = reqValid && !reqWrite && (target == TGT_IO);
    strb.ioWrite   = reqValid &&  reqWrite && (target == TGT_IO);
    strb.fault     = reqValid && (target == TGT_NONE);
    strb.fetchTrap = reqValid && (target == TGT_NONE) && reqFetch && !reqWrite;
  end

endmodule

// File: rtl/busdec_dpath.sv
module busdec_dpath
  import busdec_pkg::*;
#(
  parameter int          OFS_W     = 24,
  parameter logic [31:0] PRIV_SIZE = 32'h0001_0000,
  parameter logic [31:0] MAIN_SIZE = 32'h0040_0000,
  parameter logic [31:0] TCM_SIZE  = 32'h0000_8000,
  parameter logic [31:0] ROM_SIZE  = 32'h0000_4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [31:0]      reqAddr,
  input  logic [1:0]       reqSize,
  input  logic             reqWrite,
  input  logic [31:0]      reqWdata,
  input  ctlStrobe_t       strb,
  input  logic [OFS_W-1:0] sharedSize,
  output logic             memEn,
  output logic [2:0]       memSel,
  output logic             memWe,
  output logic [OFS_W-1:0] memOffset,
  output logic [3:0]       memBe,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  output logic             ioRe,
  output logic             ioWe,
  output logic [23:0]      ioAddrLo,
  output logic [23:0]      ioAddrHi,
  input  logic [15:0]      ioRdLo,
  input  logic [15:0]      ioRdHi,
  output logic [31:0]      ioWdata,
  output logic [3:0]       ioBe,
  output logic             rspValid,
  output logic [31:0]      rspData,
  output logic [1:0]       rspWait,
  output logic             rspErr
);

  localparam logic [31:0] PRIV_MASK = PRIV_SIZE - 32'd1;
  localparam logic [31:0] MAIN_MASK = MAIN_SIZE - 32'd1;
  localparam logic [31:0] TCM_MASK  = TCM_SIZE  - 32'd1;
  localparam logic [31:0] ROM_MASK  = ROM_SIZE  - 32'd1;
  localparam int          LANES     = 4;

  logic [31:0] maskedAddr;
  logic [31:0] sharedMask;
  logic [31:0] laneData;
  logic [3:0]  laneBe;
  logic [31:0] srcWord;
  logic [31:0] ioWord;
  logic [31:0] loadData;
  logic [31:0] shAmt;

  function automatic logic [31:0] rotr(input logic [31:0] v, input logic [4:0] n);
    logic [63:0] dbl;
    dbl = {v, v} >> n;
    return dbl[31:0];
  endfunction

  assign sharedMask = 32'(sharedSize) - 32'd1;

  always_comb begin
    unique case (strb.target)
      TGT_PRIV:   maskedAddr = reqAddr & PRIV_MASK;
      TGT_SHARED: maskedAddr = reqAddr & sharedMask;
      TGT_MAIN:   maskedAddr = reqAddr & MAIN_MASK;
      TGT_TCM:    maskedAddr = reqAddr & TCM_MASK;
      TGT_ROM:    maskedAddr = reqAddr & ROM_MASK;
      default:    maskedAddr = '0;
    endcase
  end

  // store lane formatting, one enable per byte lane
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_comb begin
      unique case (reqSize)
        SZ_BYTE: begin
          laneData[lane*8 +: 8] = reqWdata[7:0];
          laneBe[lane]          = (reqAddr[1:0] == 2'(lane));
        end
        SZ_HALF: begin
          laneData[lane*8 +: 8] = reqWdata[(lane%2)*8 +: 8];
          laneBe[lane]          = (reqAddr[1] == lane[1]);
        end
        default: begin
          laneData[lane*8 +: 8] = reqWdata[lane*8 +: 8];
          laneBe[lane]          = 1'b1;
        end
      endcase
    end
  end

  assign memEn     = strb.memRead || strb.memWrite;
  assign memWe     = strb.memWrite;
  assign memSel    = strb.target;
  assign memOffset = {maskedAddr[OFS_W-1:2], 2'b00};
  assign memBe     = strb.memWrite ? laneBe : 4'b0000;
  assign memWdata  = laneData;

  assign ioRe    = strb.ioRead;
  assign ioWe    = strb.ioWrite;
  assign ioWdata = laneData;
  assign ioBe    = strb.ioWrite ? laneBe : 4'b0000;
  assign ioAddrHi = {reqAddr[23:2], 2'b10};

  always_comb begin
    if (reqWrite || reqSize == SZ_WORD) ioAddrLo = {reqAddr[23:2], 2'b00};
    else                                ioAddrLo = {reqAddr[23:1], 1'b0};
  end

  // IO read placed on the lanes a memory word would use
  always_comb begin
    if (reqSize == SZ_WORD) ioWord = {ioRdHi, ioRdLo};
    else if (reqAddr[1])    ioWord = {ioRdLo, 16'h0000};
    else                    ioWord = {16'h0000, ioRdLo};
  end

  assign srcWord = strb.ioRead ? ioWord : memRdata;
  assign shAmt   = 32'(reqAddr[1:0]) << 3;

  always_comb begin
    logic [15:0] half;
    half = reqAddr[1] ? srcWord[31:16] : srcWord[15:0];
    unique case (reqSize)
      SZ_BYTE: loadData = {24'd0, srcWord[shAmt[4:0] +: 8]};
      SZ_HALF: loadData = rotr({16'd0, half}, {reqAddr[0], 3'b000});
      default: loadData = rotr(srcWord, {reqAddr[1:0], 3'b000});
    endcase
    if (strb.fetchTrap)  loadData = TRAP_WORD;
    else if (strb.fault) loadData = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspWait  <= 2'd0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspData  <= (reqValid && !reqWrite) ? loadData : '0;
      rspWait  <= !reqValid ? 2'd0 : (reqWrite ? 2'd1 : 2'd2);
      rspErr   <= strb.fault;
    end
  end

endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
  import busdec_pkg::*;
#(
  parameter int          OFS_W        = 24,
  parameter logic [31:0] PRIV_BASE    = 32'h0380_0000,
  parameter logic [31:0] PRIV_SIZE    = 32'h0001_0000,
  parameter logic [31:0] MAIN_SIZE    = 32'h0040_0000,
  parameter logic [31:0] TCM_SIZE     = 32'h0000_8000,
  parameter logic [31:0] ROM_SIZE     = 32'h0000_4000,
  parameter bit          ROM_PRESENT  = 1'b0,
  parameter logic [OFS_W-1:0] SHARED_RESET = 24'h00_8000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [31:0]      reqAddr,
  input  logic [1:0]       reqSize,
  input  logic             reqWrite,
  input  logic             reqFetch,
  input  logic [31:0]      reqWdata,
  input  logic [4:0]       tcmSizeField,
  input  logic             cfgWe,
  input  logic [OFS_W-1:0] cfgShared,
  output logic             memEn,
  output logic [2:0]       memSel,
  output logic             memWe,
  output logic [OFS_W-1:0] memOffset,
  output logic [3:0]       memBe,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  output logic             ioRe,
  output logic             ioWe,
  output logic [23:0]      ioAddrLo,
  output logic [23:0]      ioAddrHi,
  input  logic [15:0]      ioRdLo,
  input  logic [15:0]      ioRdHi,
  output logic [31:0]      ioWdata,
  output logic [3:0]       ioBe,
  output logic             rspValid,
  output logic [31:0]      rspData,
  output logic [1:0]       rspWait,
  output logic             rspErr
);

  ctlStrobe_t       strb;
  logic [OFS_W-1:0] sharedSize;

  busdec_ctrl #(
    .OFS_W(OFS_W), .PRIV_BASE(PRIV_BASE),
    .ROM_PRESENT(ROM_PRESENT), .SHARED_RESET(SHARED_RESET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqFetch(reqFetch), .tcmSizeField(tcmSizeField),
    .cfgWe(cfgWe), .cfgShared(cfgShared), .strb(strb), .sharedSize(sharedSize)
  );

  busdec_dpath #(
    .OFS_W(OFS_W), .PRIV_SIZE(PRIV_SIZE), .MAIN_SIZE(MAIN_SIZE),
    .TCM_SIZE(TCM_SIZE), .ROM_SIZE(ROM_SIZE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .strb(strb), .sharedSize(sharedSize),
    .memEn(memEn), .memSel(memSel), .memWe(memWe), .memOffset(memOffset),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .ioRe(ioRe), .ioWe(ioWe), .ioAddrLo(ioAddrLo), .ioAddrHi(ioAddrHi),
    .ioRdLo(ioRdLo), .ioRdHi(ioRdHi), .ioWdata(ioWdata), .ioBe(ioBe),
    .rspValid(rspValid), .rspData(rspData), .rspWait(rspWait), .rspErr(rspErr)
  );

endmodule

// File: rtl/busdec_chk.sv
module busdec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic        reqFetch,
  input logic [31:0] reqAddr,
  input logic [4:0]  tcmSizeField,
  input logic        memEn,
  input logic        memWe,
  input logic [2:0]  memSel,
  input logic        ioRe,
  input logic        ioWe,
  input logic        rspValid,
  input logic        rspErr,
  input logic [1:0]  rspWait,
  input logic [31:0] rspData
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!memEn && !ioRe && !ioWe)); // R2

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    !(memEn && (ioRe || ioWe))); // R2

  AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memSel == 3'd4) |-> !memWe); // R12

  AST_LOAD_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> (rspWait == 2'd2)); // R8

  AST_STORE_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspWait == 2'd1)); // R8

  AST_TCM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memSel == 3'd3) |-> ({32'd0, reqAddr} < (64'd512 << tcmSizeField))); // R10

  AST_ERR_HAS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid); // R12

  AST_ERR_STORE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !memEn && !ioWe) |=> rspErr); // R12

  AST_TRAP_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFetch && !reqWrite) ##1 rspErr |-> (rspData == 32'hE710B710)); // R11

  AST_ERR_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFetch && !reqWrite) ##1 rspErr |-> (rspData == 32'd0)); // R12

endmodule

bind bus_region_decoder busdec_chk u_busdec_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqFetch(reqFetch), .reqAddr(reqAddr), .tcmSizeField(tcmSizeField),
  .memEn(memEn), .memWe(memWe), .memSel(memSel), .ioRe(ioRe), .ioWe(ioWe),
  .rspValid(rspValid), .rspErr(rspErr), .rspWait(rspWait), .rspData(rspData)
);

// File: tb/test_bus_region_decoder.sv
module test_bus_region_decoder;

  typedef struct packed {
    logic [4:0]  fld;
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic        fetch;
    logic [31:0] wdata;
    logic [31:0] expData;
    logic        expErr;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{5'd6, 32'h0200_0010, 2'd2, 1'b1, 1'b0, 32'h1122_3344, 32'h0,           1'b0, 4'd8},  // R8 store
    '{5'd6, 32'h0240_0010, 2'd2, 1'b0, 1'b0, 32'h0,         32'h1122_3344,   1'b0, 4'd4},  // R4 mirror
    '{5'd6, 32'h0200_0011, 2'd2, 1'b0, 1'b0, 32'h0,         32'h4411_2233,   1'b0, 4'd7},  // R7 word rot
    '{5'd6, 32'h0200_0012, 2'd1, 1'b0, 1'b0, 32'h0,         32'h0000_1122,   1'b0, 4'd7},  // R7 half
    '{5'd6, 32'h0200_0013, 2'd1, 1'b0, 1'b0, 32'h0,         32'h2200_0011,   1'b0, 4'd7},  // R7 half rot
    '{5'd6, 32'h0200_0011, 2'd0, 1'b0, 1'b0, 32'h0,         32'h0000_0033,   1'b0, 4'd7},  // R7 byte
    '{5'd6, 32'h0200_0012, 2'd0, 1'b1, 1'b0, 32'h0000_00AB, 32'h0,           1'b0, 4'd3},  // R3 byte store
    '{5'd6, 32'h0200_0010, 2'd2, 1'b0, 1'b0, 32'h0,         32'h11AB_3344,   1'b0, 4'd3},  // R3
    '{5'd6, 32'h0200_0016, 2'd1, 1'b1, 1'b0, 32'h0000_BEEF, 32'h0,           1'b0, 4'd3},  // R3 half store
    '{5'd6, 32'h0200_0014, 2'd2, 1'b0, 1'b0, 32'h0,         32'hBEEF_0000,   1'b0, 4'd3},  // R3
    '{5'd6, 32'h0300_0020, 2'd2, 1'b1, 1'b0, 32'hCAFE_F00D, 32'h0,           1'b0, 4'd5},  // R5 shared
    '{5'd6, 32'h0300_8020, 2'd2, 1'b0, 1'b0, 32'h0,         32'hCAFE_F00D,   1'b0, 4'd5},  // R5 shared mask
    '{5'd6, 32'h0380_0020, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0,           1'b0, 4'd5},  // R5 private
    '{5'd6, 32'h0381_0024, 2'd2, 1'b1, 1'b0, 32'h0BAD_BEEF, 32'h0,           1'b0, 4'd5},  // R5
    '{5'd6, 32'h0380_0024, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0BAD_BEEF,   1'b0, 4'd5},  // R5 private mask
    '{5'd6, 32'h0412_3104, 2'd2, 1'b0, 1'b0, 32'h0,         32'h6B5C_6B5E,   1'b0, 4'd9},  // R9 word io
    '{5'd6, 32'h0400_0203, 2'd1, 1'b0, 1'b0, 32'h0,         32'h5800_0058,   1'b0, 4'd9},  // R9 half io
    '{5'd6, 32'h0700_0000, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0,           1'b1, 4'd12}, // R12 unmapped load
    '{5'd6, 32'h0700_0000, 2'd2, 1'b0, 1'b1, 32'h0,         32'hE710_B710,   1'b1, 4'd11}, // R11 unmapped fetch
    '{5'd6, 32'hFF00_0000, 2'd2, 1'b0, 1'b1, 32'h0,         32'hE710_B710,   1'b1, 4'd11}, // R11 absent rom
    '{5'd6, 32'h0000_7FFC, 2'd2, 1'b1, 1'b0, 32'h1234_5678, 32'h0,           1'b0, 4'd10}, // R10 in bound
    '{5'd6, 32'h0000_7FFC, 2'd2, 1'b0, 1'b0, 32'h0,         32'h1234_5678,   1'b0, 4'd10}, // R10
    '{5'd6, 32'h0000_8000, 2'd2, 1'b1, 1'b0, 32'h0000_0099, 32'h0,           1'b1, 4'd10}, // R10 rejected
    '{5'd31,32'h0000_0000, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0,           1'b0, 4'd10}, // R10 drop seen
    '{5'd31,32'h0100_7FFC, 2'd2, 1'b0, 1'b0, 32'h0,         32'h1234_5678,   1'b0, 4'd10}, // R10 mirror
    '{5'd6, 32'h0100_0000, 2'd2, 1'b0, 1'b1, 32'h0,         32'hE710_B710,   1'b1, 4'd11}, // R11 tcm reject
    '{5'd6, 32'h0200_0010, 2'd2, 1'b0, 1'b1, 32'h0,         32'h11AB_3344,   1'b0, 4'd2}   // R2 fetch ok
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic        reqFetch = 1'b0;
  logic [31:0] reqWdata = '0;
  logic [4:0]  tcmSizeField = 5'd6;
  logic        cfgWe = 1'b0;
  logic [23:0] cfgShared = '0;
  logic        memEn, memWe, ioRe, ioWe, rspValid, rspErr;
  logic [2:0]  memSel;
  logic [23:0] memOffset, ioAddrLo, ioAddrHi;
  logic [3:0]  memBe, ioBe;
  logic [31:0] memWdata, memRdata, ioWdata, rspData;
  logic [15:0] ioRdLo, ioRdHi;
  logic [1:0]  rspWait;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] bm [0:7][0:63];

  always #2 clk = ~clk;

  bus_region_decoder i_bus_region_decoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqFetch(reqFetch),
    .reqWdata(reqWdata), .tcmSizeField(tcmSizeField), .cfgWe(cfgWe),
    .cfgShared(cfgShared), .memEn(memEn), .memSel(memSel), .memWe(memWe),
    .memOffset(memOffset), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .ioRe(ioRe), .ioWe(ioWe), .ioAddrLo(ioAddrLo),
    .ioAddrHi(ioAddrHi), .ioRdLo(ioRdLo), .ioRdHi(ioRdHi), .ioWdata(ioWdata),
    .ioBe(ioBe), .rspValid(rspValid), .rspData(rspData), .rspWait(rspWait),
    .rspErr(rspErr)
  );

  assign memRdata = bm[memSel][memOffset[7:2]];
  assign ioRdLo   = ioAddrLo[15:0] ^ 16'h5A5A;
  assign ioRdHi   = ioAddrHi[15:0] ^ 16'h5A5A;

  always @(posedge clk) begin
    if (memEn && memWe) begin
      for (int b = 0; b < 4; b++)
        if (memBe[b]) bm[memSel][memOffset[7:2]][b*8 +: 8] <= memWdata[b*8 +: 8];
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] fld, input logic [31:0] a, input logic [1:0] sz,
                       input logic wr, input logic fe, input logic [31:0] wd);
    @(negedge clk);
    tcmSizeField = fld; reqAddr = a; reqSize = sz;
    reqWrite = wr; reqFetch = fe; reqWdata = wd; reqValid = 1'b1;
    #1;
  endtask

  task automatic release_req();
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqFetch = 1'b0;
  endtask

  initial begin
    for (int t = 0; t < 8; t++)
      for (int w = 0; w < 64; w++) bm[t][w] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 reset rsp", {61'd0, rspValid, rspErr, 1'b0}, 64'd0);
    check("R1 reset wait", {62'd0, rspWait}, 64'd0);
    check("R1 reset strobes", {61'd0, memEn, ioRe, ioWe}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].fld, VECS[i].addr, VECS[i].size, VECS[i].wr, VECS[i].fetch, VECS[i].wdata);
      release_req();
      check($sformatf("R%0d vec%0d data", VECS[i].tag, i), {32'd0, rspData}, {32'd0, VECS[i].expData});
      check($sformatf("R%0d vec%0d err/valid", VECS[i].tag, i), {62'd0, rspValid, rspErr},
            {62'd0, 1'b1, VECS[i].expErr});
      check($sformatf("R8 vec%0d wait", i), {62'd0, rspWait}, VECS[i].wr ? 64'd1 : 64'd2);
    end

    // R12 error pulse lasts one cycle
    @(negedge clk);
    check("R12 err pulse ends", {62'd0, rspValid, rspErr}, 64'd0);

    // R6 shared size zero routes to private RAM
    @(negedge clk);
    cfgShared = 24'h0; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    drive(5'd6, 32'h0300_0020, 2'd2, 1'b0, 1'b0, 32'h0);
    check("R6 zero size sel private", {61'd0, memSel}, 64'd0);
    release_req();
    check("R6 zero size data", {32'd0, rspData}, 64'd0);
    cfgShared = 24'h4000; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    drive(5'd6, 32'h0300_4020, 2'd2, 1'b0, 1'b0, 32'h0);
    check("R6 new size offset", {40'd0, memOffset}, 64'h20);
    release_req();
    check("R6 new size data", {32'd0, rspData}, 64'hCAFE_F00D);

    // R3 byte store lanes
    drive(5'd6, 32'h0200_0013, 2'd0, 1'b1, 1'b0, 32'h0000_00CD);
    check("R3 byte be", {60'd0, memBe}, 64'h8);
    check("R3 byte data", {32'd0, memWdata}, 64'hCDCD_CDCD);
    check("R2 main sel", {61'd0, memSel}, 64'd2);
    release_req();

    // R9 IO write address masked to 24 bits
    drive(5'd6, 32'h04FF_0012, 2'd2, 1'b1, 1'b0, 32'h5566_7788);
    check("R9 io write strobe", {62'd0, ioWe, memEn}, 64'h2);
    check("R9 io write addr", {40'd0, ioAddrLo}, 64'hFF_0010);
    release_req();

    // R12 faulting stores strobe nothing
    drive(5'd6, 32'h0500_0000, 2'd2, 1'b1, 1'b0, 32'h1);
    check("R12 unmapped store", {62'd0, memEn, ioWe}, 64'd0);
    release_req();
    check("R12 unmapped store err", {63'd0, rspErr}, 64'd1);
    drive(5'd6, 32'hFF00_0000, 2'd2, 1'b1, 1'b0, 32'h1);
    check("R12 rom store", {62'd0, memEn, ioWe}, 64'd0);
    release_req();
    check("R12 rom store err", {63'd0, rspErr}, 64'd1);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule